// File: doc/BRIEF.md
# Signal Generator Parameter Controller

This block keeps the user-facing settings of a waveform generator and changes them in response to front-panel controls. Three single-cycle press pulses arrive already cleaned of bounce: one selects the next waveform, one raises the output level, and one (from the push switch built into the rotary knob) widens the frequency step. The knob's two quadrature channels are synchronised and decoded into up and down counts. Each count moves the frequency by the current step. The result is held between 0 Hz and 20,000,000 Hz.

The settings come out as plain registers. These are a waveform code, a three-colour indicator, a level code in tenths of a volt peak-to-peak, the step in hertz and the frequency in hertz. A downstream stage turns the frequency into a phase increment.

Two small state machines carry the sequencing. The waveform selector has three states. SINE moves to TRI on a waveform press, TRI moves to SQUARE, and SQUARE moves back to SINE. With no press, each state holds. The knob decoder has two states. PH_LOW moves to PH_HIGH when the synchronised A channel reads 1, and emits one count on that move. PH_HIGH moves back to PH_LOW when A reads 0, and emits nothing.

Top module: `sg_param_ctrl`

## Requirements
- R1: `wave_sel` resets to 0 (sine). Each waveform press advances it in the order 0 (sine), 1 (triangle), 2 (square) and then back to 0. The value 3 never appears. The new value is visible after the clock edge that samples the press.
- R2: `rgb` is one-hot, with bit 2 for red, bit 1 for green and bit 0 for blue. It shows 3'b100 for sine, 3'b010 for triangle and 3'b001 for square.
- R3: `amp_code` resets to 1 (0.1 Vpp). Each level press adds 1. A press at 10 (1.0 Vpp) returns it to 1.
- R4: `step_hz` resets to 1. Each step press multiplies it by 10. A press at 10,000,000 returns it to 1.
- R5: `freq_hz` resets to 1000. A rising edge on `enc_a` while `enc_b` is low adds `step_hz`. A rising edge on `enc_a` while `enc_b` is high subtracts `step_hz`. The result appears on the third rising clock edge after the input change: two synchroniser stages, then the register.
- R6: An increase that would pass 20,000,000 leaves `freq_hz` at exactly 20,000,000.
- R7: A decrease that would go below zero leaves `freq_hz` at 0.
- R8: A falling edge on `enc_a`, and any change of `enc_b` alone, leave `freq_hz` unchanged.
- R9: When a count and a step press fall in the same cycle, the count uses the step in force before the press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wave_btn | input | 1 | One-cycle waveform press pulse |
| amp_btn | input | 1 | One-cycle level press pulse |
| step_btn | input | 1 | One-cycle knob push pulse |
| enc_a | input | 1 | Knob quadrature channel A (asynchronous) |
| enc_b | input | 1 | Knob quadrature channel B (asynchronous) |
| wave_sel | output | 2 | Waveform code: 0 sine, 1 triangle, 2 square |
| rgb | output | 3 | Indicator, bit 2 red, bit 1 green, bit 0 blue |
| amp_code | output | 4 | Level in tenths of a volt peak-to-peak, 1 to 10 |
| step_hz | output | 24 | Current frequency step in hertz |
| freq_hz | output | 25 | Current frequency in hertz |

## Verification
A wrong decoder phase shows up as a missing or doubled count. `freq_hz` then differs from the reference three edges after the faulty A transition. A wrong step or a wrong saturation limit shows up at the next count after it. A wrong waveform or level state shows on the outputs one edge after the press that reaches it. Every output is compared against a behavioural model each cycle, so each of these faults is reported in the cycle where it first becomes visible at the ports.

// File: rtl/sg_pkg.sv
package sg_pkg;
    typedef enum logic [1:0] {
        WAVE_SINE   = 2'd0,
        WAVE_TRI    = 2'd1,
        WAVE_SQUARE = 2'd2
    } wave_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } qphase_t;

    function automatic int unsigned pow10(input int unsigned n);
        int unsigned r;
        r = 1;
        for (int i = 0; i < 32; i++) begin
            if (i < n) r = r * 10;
        end
        return r;
    endfunction
endpackage

// File: rtl/quad_decoder.sv
module quad_decoder
    import sg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_a,
    input  logic enc_b,
    output logic cnt_up,
    output logic cnt_dn
);
    logic [SYNC_STAGES-1:0] a_sh, b_sh;
    logic a_s, b_s;
    qphase_t phase_q, phase_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_sh <= '0;
            b_sh <= '0;
        end else begin
            a_sh <= {a_sh[SYNC_STAGES-2:0], enc_a};
            b_sh <= {b_sh[SYNC_STAGES-2:0], enc_b};
        end
    end

    assign a_s = a_sh[SYNC_STAGES-1];
    assign b_s = b_sh[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_LOW;
        else        phase_q <= phase_nx;
    end

    // next state and count outputs
    always_comb begin
        phase_nx = phase_q;
        cnt_up   = 1'b0;
        cnt_dn   = 1'b0;
        unique case (phase_q)
            PH_LOW: begin
                if (a_s) begin
                    phase_nx = PH_HIGH;
                    cnt_up   = !b_s;
                    cnt_dn   = b_s;
                end
            end
            PH_HIGH: begin
                if (!a_s) phase_nx = PH_LOW;
            end
            default: phase_nx = PH_LOW;
        endcase
    end

    assert_single_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cnt_up, cnt_dn}));
    assert_one_per_detent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_up || cnt_dn) |=> !(cnt_up || cnt_dn));
endmodule

// File: rtl/wave_select.sv
module wave_select
    import sg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       press,
    output logic [1:0] wave_sel,
    output logic [2:0] rgb
);
    wave_t state_q, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WAVE_SINE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            WAVE_SINE:   if (press) state_nx = WAVE_TRI;
            WAVE_TRI:    if (press) state_nx = WAVE_SQUARE;
            WAVE_SQUARE: if (press) state_nx = WAVE_SINE;
            default:     state_nx = WAVE_SINE;
        endcase
    end

    // output process
    always_comb begin
        wave_sel = state_q;
        unique case (state_q)
            WAVE_SINE:   rgb = 3'b100;
            WAVE_TRI:    rgb = 3'b010;
            WAVE_SQUARE: rgb = 3'b001;
            default:     rgb = 3'b100;
        endcase
    end

    assert_wave_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wave_sel != 2'd3);
    assert_wave_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !press |=> $stable(wave_sel));
    assert_rgb_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(rgb));
endmodule

// File: rtl/level_control.sv
module level_control #(
    parameter int AMP_MIN = 1,
    parameter int AMP_MAX = 10,
    localparam int AMP_W  = $clog2(AMP_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             amp_press,
    input  logic             step_press,
    output logic [AMP_W-1:0] amp_code,
    output logic [23:0]      step_hz
);
    localparam int unsigned STEP_MAX_I = sg_pkg::pow10(7);
    localparam logic [23:0] STEP_MAX   = 24'(STEP_MAX_I);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            amp_code <= AMP_W'(AMP_MIN);
        end else if (amp_press) begin
            if (amp_code == AMP_W'(AMP_MAX)) amp_code <= AMP_W'(AMP_MIN);
            else                             amp_code <= amp_code + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_hz <= 24'd1;
        end else if (step_press) begin
            if (step_hz == STEP_MAX) step_hz <= 24'd1;
            else                     step_hz <= (step_hz << 3) + (step_hz << 1);
        end
    end

    assert_amp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        amp_code >= AMP_W'(AMP_MIN) && amp_code <= AMP_W'(AMP_MAX));
    assert_amp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !amp_press |=> $stable(amp_code));
    assert_step_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !step_press |=> $stable(step_hz));
    assert_step_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_hz != 24'd0 && step_hz <= STEP_MAX);
endmodule

// File: rtl/freq_accum.sv
module freq_accum #(
    parameter int FREQ_MAX   = 20_000_000,
    parameter int FREQ_RESET = 1000,
    parameter int STEP_W     = 24,
    localparam int FREQ_W    = $clog2(FREQ_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_up,
    input  logic              cnt_dn,
    input  logic [STEP_W-1:0] step_hz,
    output logic [FREQ_W-1:0] freq_hz
);
    localparam logic [FREQ_W-1:0] F_MAX = FREQ_W'(FREQ_MAX);

    logic [FREQ_W-1:0] step_ext, headroom;

    assign step_ext = FREQ_W'(step_hz);
    assign headroom = F_MAX - freq_hz;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_hz <= FREQ_W'(FREQ_RESET);
        end else if (cnt_up) begin
            if (step_ext > headroom) freq_hz <= F_MAX;
            else                     freq_hz <= freq_hz + step_ext;
        end else if (cnt_dn) begin
            if (step_ext > freq_hz) freq_hz <= '0;
            else                    freq_hz <= freq_hz - step_ext;
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        freq_hz <= F_MAX);
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_up || cnt_dn) |=> $stable(freq_hz));
    assert_up_no_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_up |=> freq_hz >= $past(freq_hz));
    assert_dn_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_dn |=> freq_hz <= $past(freq_hz));
endmodule

// File: rtl/sg_param_ctrl.sv
module sg_param_ctrl #(
    parameter int FREQ_MAX    = 20_000_000,
    parameter int FREQ_RESET  = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wave_btn,
    input  logic        amp_btn,
    input  logic        step_btn,
    input  logic        enc_a,
    input  logic        enc_b,
    output logic [1:0]  wave_sel,
    output logic [2:0]  rgb,
    output logic [3:0]  amp_code,
    output logic [23:0] step_hz,
    output logic [24:0] freq_hz
);
    logic cnt_up, cnt_dn;

    quad_decoder #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .cnt_up(cnt_up), .cnt_dn(cnt_dn)
    );

    wave_select u_wave (
        .clk(clk), .rst_n(rst_n), .press(wave_btn),
        .wave_sel(wave_sel), .rgb(rgb)
    );

    level_control #(.AMP_MIN(1), .AMP_MAX(10)) u_lvl (
        .clk(clk), .rst_n(rst_n), .amp_press(amp_btn), .step_press(step_btn),
        .amp_code(amp_code), .step_hz(step_hz)
    );

    freq_accum #(.FREQ_MAX(FREQ_MAX), .FREQ_RESET(FREQ_RESET), .STEP_W(24)) u_freq (
        .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
        .step_hz(step_hz), .freq_hz(freq_hz)
    );
endmodule

// File: tb/tb_sg_param_ctrl.sv
module tb_sg_param_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  F_MAX = 20_000_000;

    logic clk = 0, rst_n = 0;
    logic wave_btn = 0, amp_btn = 0, step_btn = 0, enc_a = 0, enc_b = 0;
    logic [1:0]  wave_sel;
    logic [2:0]  rgb;
    logic [3:0]  amp_code;
    logic [23:0] step_hz;
    logic [24:0] freq_hz;

    int checks = 0, errors = 0, cycles = 0;
    bit compare_on = 0;

    // reference model state
    int m_wave = 0, m_amp = 1, m_step = 1, m_freq = 1000;
    int m_a1 = 0, m_a2 = 0, m_b1 = 0, m_b2 = 0, m_alast = 0;

    sg_param_ctrl dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_wave = 0; m_amp = 1; m_step = 1; m_freq = 1000;
            m_a1 = 0; m_a2 = 0; m_b1 = 0; m_b2 = 0; m_alast = 0;
        end else begin
            if (m_alast == 0 && m_a2 == 1) begin
                if (m_b2 == 0) m_freq = (m_freq + m_step > F_MAX) ? F_MAX : m_freq + m_step;
                else           m_freq = (m_freq < m_step) ? 0 : m_freq - m_step;
            end
            m_alast = m_a2;
            m_a2 = m_a1; m_a1 = enc_a;
            m_b2 = m_b1; m_b1 = enc_b;
            if (wave_btn) m_wave = (m_wave + 1) % 3;
            if (amp_btn)  m_amp  = (m_amp == 10) ? 1 : m_amp + 1;
            if (step_btn) m_step = (m_step == 10_000_000) ? 1 : m_step * 10;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rgb_of(int w);
        return (w == 0) ? 4 : (w == 1) ? 2 : 1;
    endfunction

    always @(negedge clk) begin
        cycles++;
        if (compare_on) begin
            check("R1 wave_sel", wave_sel, m_wave);
            check("R2 rgb", rgb, rgb_of(m_wave));
            check("R3 amp_code", amp_code, m_amp);
            check("R4 step_hz", step_hz, m_step);
            check("R5 freq_hz", freq_hz, m_freq);
        end
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 200000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1;
        @(negedge clk); sig = 0;
    endtask

    // dir 1 = up (A rises with B low), 0 = down (A rises with B high)
    task automatic detent(bit up);
        if (up) begin
            enc_a = 1; idle(4); enc_b = 1; idle(4); enc_a = 0; idle(4); enc_b = 0; idle(4);
        end else begin
            enc_b = 1; idle(4); enc_a = 1; idle(4); enc_b = 0; idle(4); enc_a = 0; idle(4);
        end
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset wave", wave_sel, 0);
        check("R2 reset rgb", rgb, 3'b100);
        check("R3 reset amp", amp_code, 1);
        check("R4 reset step", step_hz, 1);
        check("R5 reset freq", freq_hz, 1000);
        compare_on = 1;

        pulse(wave_btn); idle(1); check("R2 green", rgb, 3'b010);
        pulse(wave_btn); idle(1); check("R2 blue", rgb, 3'b001);
        pulse(wave_btn); idle(1); check("R1 wrap to sine", wave_sel, 0);

        for (int i = 0; i < 9; i++) pulse(amp_btn);
        idle(1); check("R3 top level", amp_code, 10);
        pulse(amp_btn); idle(1); check("R3 wrap level", amp_code, 1);

        detent(1); check("R5 up one", freq_hz, 1001);
        detent(0); detent(0); check("R5 down two", freq_hz, 999);

        // R5 latency: A rises at a negedge, visible after the third rising edge
        enc_a = 1; idle(2); check("R5 not yet", freq_hz, 999);
        idle(1); check("R5 third edge", freq_hz, 1000);
        enc_a = 0; idle(4);

        // R8: B toggling alone and A falling
        for (int i = 0; i < 3; i++) begin enc_b = ~enc_b; idle(4); end
        enc_b = 0; idle(4);
        check("R8 no change", freq_hz, 1000);

        for (int i = 0; i < 7; i++) pulse(step_btn);
        idle(1); check("R4 top step", step_hz, 10_000_000);
        detent(1); detent(1); check("R6 saturate high", freq_hz, F_MAX);
        detent(0); check("R7 step down", freq_hz, 10_000_000);
        detent(0); detent(0); check("R7 saturate low", freq_hz, 0);
        pulse(step_btn); idle(1); check("R4 wrap step", step_hz, 1);

        // R9: step press coincides with the count
        pulse(step_btn); idle(1);
        enc_a = 1; idle(2); step_btn = 1; idle(1); step_btn = 0;
        check("R9 old step used", freq_hz, 10);
        check("R9 step advanced", step_hz, 100);
        enc_a = 0; idle(4);
        detent(1); check("R9 new step used", freq_hz, 110);

        // reset in mid-run
        pulse(wave_btn); pulse(amp_btn);
        compare_on = 0;
        rst_n = 0; idle(2); rst_n = 1; idle(1);
        check("R1 re-reset", wave_sel, 0);
        check("R5 re-reset", freq_hz, 1000);
        compare_on = 1;
        idle(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule